// File: doc/BRIEF.md
# SCSI DMA Transfer Length Controller

This block decides how many bytes one DMA transfer of a SCSI bus controller moves, moves them over a byte-wide valid/ready memory handshake, and posts the completion state. Software first writes a 16-bit byte count as two bytes. A command write with the DMA flag set copies that count into the readable count register. When `xfer_go` starts a transfer, the block takes the smaller of two values as the length. The first is the programmed count. The second depends on the phase: a fixed command-phase limit, or the magnitude of the signed number of bytes the device still has to move. The sign of that device count also gives the direction of the transfer.

Bytes move one per accepted beat. In the data phase, beats are offered only while the device reports data ready. Most transfers end as soon as the last byte moves. If the device runs out of bytes before the programmed count does, the block holds the completion until the device reports that it is done. Completion sets the terminal-count status bit and loads the bus-service code into the interrupt register. It also clears the count and raises the interrupt request, which stays high until it is acknowledged.

Top module: `xfer_len_ctrl`

## Requirements
- R1: A write of `wr_data` to `wr_addr` 0 stores the low count byte, and a write to address 1 stores the middle byte. A write to address 2 with bit 7 set copies the count (low byte + middle byte × 256) to `xfer_cnt` on the next cycle.
- R2: The following leave `xfer_cnt` unchanged: a write to address 2 with bit 7 clear, and any write to address 0 or 1 on its own.
- R3: With `ZERO_IS_MAX` set, a programmed count of 0 stands for 65536 bytes.
- R4: If `cmd_phase` is high at start, the length is min(count, 32) and `mem_to_dev` is 1.
- R5: If `cmd_phase` is low at start, `dev_remain` is read as a two's-complement value. A negative value gives `mem_to_dev`=1 and length min(count, −value). Zero or a positive value gives `mem_to_dev`=0 and length min(count, value).
- R6: `xfer_go` while idle starts a transfer. After that edge, `busy` is 1 and status bit 4 (terminal count, 0x10) is 0.
- R7: Each cycle with `mem_valid` and `mem_ready` both high moves one byte. Exactly the computed length is moved.
- R8: In the data phase, `mem_valid` stays low while `dev_avail` is low. In the command phase, `dev_avail` has no effect.
- R9: On completion, `stat_reg` bits 4 and 7 are set, `intr_reg` becomes 0x10 (bus service), `xfer_cnt` becomes 0 and `irq` rises. Without a hold, this takes effect in the cycle after the last beat.
- R10: In the data phase, when the magnitude of `dev_remain` is below the count, the block waits after the last beat with `irq` low. It completes in the cycle after `dev_done`.
- R11: `irq` (status bit 7) stays high until `irq_ack` is given, and then clears on the next cycle.
- R12: `xfer_go` while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 low count, 1 middle count, 2 command |
| wr_data | input | BYTE_W | Write data; bit 7 of a command is the DMA flag |
| xfer_go | input | 1 | Start a transfer |
| cmd_phase | input | 1 | Bus is in the command phase |
| dev_remain | input | DEV_W | Signed bytes the device still has to move |
| dev_avail | input | 1 | Device data ready |
| dev_done | input | 1 | Device finished its part |
| mem_ready | input | 1 | Memory accepts a byte beat |
| irq_ack | input | 1 | Clears the interrupt request |
| mem_valid | output | 1 | Byte beat offered |
| mem_to_dev | output | 1 | 1: memory toward device |
| busy | output | 1 | Transfer in progress |
| xfer_cnt | output | 2*BYTE_W | Readable count register |
| stat_reg | output | 8 | Status: bit 4 terminal count, bit 7 interrupt |
| intr_reg | output | 8 | Interrupt cause register |
| irq | output | 1 | Interrupt request |

## Verification
The length rule is swept over a grid of programmed counts, some below, at and above the 32-byte command limit. These run against device counts that are negative, zero and positive, at and around the same values, in both phases. This tells the command cap apart from the device cap and separates the strict hold case from the equal case. Every point runs once with free-flowing handshakes and once with `mem_ready` and `dev_avail` stalling in different rhythms. The stalled runs show that the beat count does not depend on timing and that `dev_avail` gates only the data phase. A zero count is tried against the command cap, a large device count and a small negative device count, which exposes the 65536 reading and the hold path at full width.

// File: rtl/xlc_pkg.sv
package xlc_pkg;
   typedef enum logic [1:0] {
      XLC_IDLE = 2'd0,
      XLC_MOVE = 2'd1,
      XLC_HOLD = 2'd2
   } xlc_state_e;

   localparam int unsigned STAT_TC_BIT  = 4;
   localparam int unsigned STAT_INT_BIT = 7;
   localparam logic [7:0]  INTR_BUS_SVC = 8'h10;
   localparam logic [1:0]  ADDR_CMD     = 2'd2;
endpackage

// File: rtl/xlc_count_regs.sv
module xlc_count_regs
   import xlc_pkg::*;
#(
   parameter int BYTE_W = 8,
   localparam int CNT_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [1:0]        wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              clr_i,
   output logic [CNT_W-1:0]  cnt_o
);
   logic [BYTE_W-1:0] wbyte_q [2];
   logic              reload;

   for (genvar gi = 0; gi < 2; gi++) begin : g_wbyte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            wbyte_q[gi] <= '0;
         else if (wr_valid && wr_addr == 2'(gi))
            wbyte_q[gi] <= wr_data;
      end
   end

   assign reload = wr_valid && wr_addr == ADDR_CMD && wr_data[BYTE_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_o <= '0;
      else if (clr_i)
         cnt_o <= '0;
      else if (reload)
         cnt_o <= {wbyte_q[1], wbyte_q[0]};
   end
endmodule

// File: rtl/xlc_len_select.sv
module xlc_len_select #(
   parameter int CNT_W       = 16,
   parameter int DEV_W       = 24,
   parameter int CMD_LIM     = 32,
   parameter bit ZERO_IS_MAX = 1'b1,
   localparam int LEN_W      = CNT_W + 1,
   localparam int CW         = (DEV_W > LEN_W) ? DEV_W : LEN_W
) (
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             cmd_i,
   input  logic [DEV_W-1:0] rem_i,
   output logic [LEN_W-1:0] len_o,
   output logic             hold_o,
   output logic             to_dev_o
);
   logic [LEN_W-1:0] full_len;

   if (ZERO_IS_MAX) begin : g_zero_max
      assign full_len = (cnt_i == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, cnt_i};
   end else begin : g_zero_lit
      assign full_len = {1'b0, cnt_i};
   end

   logic             neg;
   logic [DEV_W-1:0] mag;
   logic [CW-1:0]    full_x, cap_x;

   always_comb begin
      neg      = rem_i[DEV_W-1];
      mag      = neg ? (~rem_i + 1'b1) : rem_i;
      full_x   = CW'(full_len);
      cap_x    = cmd_i ? CW'(CMD_LIM) : CW'(mag);
      len_o    = LEN_W'((full_x < cap_x) ? full_x : cap_x);
      hold_o   = !cmd_i && (CW'(mag) < full_x);
      to_dev_o = cmd_i || neg;
   end
endmodule

// File: rtl/xlc_beat_fsm.sv
module xlc_beat_fsm
   import xlc_pkg::*;
#(
   parameter int LEN_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_i,
   input  logic [LEN_W-1:0] len_i,
   input  logic             hold_i,
   input  logic             to_dev_i,
   input  logic             cmd_i,
   input  logic             dev_avail_i,
   input  logic             dev_done_i,
   input  logic             mem_ready_i,
   output logic             mem_valid_o,
   output logic             to_dev_o,
   output logic             busy_o,
   output logic             start_o,
   output logic             fin_o
);
   xlc_state_e       st_q;
   logic [LEN_W-1:0] left_q;
   logic             hold_q, dir_q, cmd_q, beat, last;

   assign start_o     = go_i && st_q == XLC_IDLE;
   assign mem_valid_o = st_q == XLC_MOVE && (cmd_q || dev_avail_i);
   assign beat        = mem_valid_o && mem_ready_i;
   assign last        = beat && left_q == LEN_W'(1);
   assign busy_o      = st_q != XLC_IDLE;
   assign to_dev_o    = dir_q;
   assign fin_o       = (start_o && len_i == '0 && !hold_i)
                     || (last && !hold_q)
                     || (st_q == XLC_HOLD && dev_done_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= XLC_IDLE;
         left_q <= '0;
         hold_q <= 1'b0;
         dir_q  <= 1'b0;
         cmd_q  <= 1'b0;
      end else begin
         unique case (st_q)
            XLC_IDLE: if (start_o) begin
               left_q <= len_i;
               hold_q <= hold_i;
               dir_q  <= to_dev_i;
               cmd_q  <= cmd_i;
               if (len_i != '0)
                  st_q <= XLC_MOVE;
               else if (hold_i)
                  st_q <= XLC_HOLD;
            end
            XLC_MOVE: if (beat) begin
               left_q <= left_q - 1'b1;
               if (last)
                  st_q <= hold_q ? XLC_HOLD : XLC_IDLE;
            end
            XLC_HOLD: if (dev_done_i)
               st_q <= XLC_IDLE;
            default: st_q <= XLC_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/xfer_len_ctrl.sv
module xfer_len_ctrl
   import xlc_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int DEV_W       = 24,
   parameter int CMD_LIM     = 32,
   parameter bit ZERO_IS_MAX = 1'b1,
   localparam int CNT_W      = 2 * BYTE_W,
   localparam int LEN_W      = CNT_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [1:0]        wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              xfer_go,
   input  logic              cmd_phase,
   input  logic [DEV_W-1:0]  dev_remain,
   input  logic              dev_avail,
   input  logic              dev_done,
   input  logic              mem_ready,
   input  logic              irq_ack,
   output logic              mem_valid,
   output logic              mem_to_dev,
   output logic              busy,
   output logic [CNT_W-1:0]  xfer_cnt,
   output logic [7:0]        stat_reg,
   output logic [7:0]        intr_reg,
   output logic              irq
);
   if (BYTE_W < 2) begin : g_bad_byte
      $error("BYTE_W must be at least 2");
   end
   if (DEV_W < 2) begin : g_bad_dev
      $error("DEV_W must be at least 2");
   end
   if (CMD_LIM < 1 || CMD_LIM > (1 << CNT_W)) begin : g_bad_lim
      $error("CMD_LIM out of range");
   end

   logic [LEN_W-1:0] len_w;
   logic             hold_w, to_dev_w, start_w, fin_w;

   xlc_count_regs #(.BYTE_W(BYTE_W)) u_cnt (
      .clk, .rst_n, .wr_valid, .wr_addr, .wr_data,
      .clr_i(fin_w), .cnt_o(xfer_cnt)
   );

   xlc_len_select #(
      .CNT_W(CNT_W), .DEV_W(DEV_W), .CMD_LIM(CMD_LIM), .ZERO_IS_MAX(ZERO_IS_MAX)
   ) u_len (
      .cnt_i(xfer_cnt), .cmd_i(cmd_phase), .rem_i(dev_remain),
      .len_o(len_w), .hold_o(hold_w), .to_dev_o(to_dev_w)
   );

   xlc_beat_fsm #(.LEN_W(LEN_W)) u_fsm (
      .clk, .rst_n, .go_i(xfer_go), .len_i(len_w), .hold_i(hold_w),
      .to_dev_i(to_dev_w), .cmd_i(cmd_phase), .dev_avail_i(dev_avail),
      .dev_done_i(dev_done), .mem_ready_i(mem_ready),
      .mem_valid_o(mem_valid), .to_dev_o(mem_to_dev), .busy_o(busy),
      .start_o(start_w), .fin_o(fin_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_reg <= '0;
         intr_reg <= '0;
      end else if (fin_w) begin
         stat_reg[STAT_TC_BIT]  <= 1'b1;
         stat_reg[STAT_INT_BIT] <= 1'b1;
         intr_reg               <= INTR_BUS_SVC;
      end else begin
         if (start_w) stat_reg[STAT_TC_BIT]  <= 1'b0;
         if (irq_ack) stat_reg[STAT_INT_BIT] <= 1'b0;
      end
   end

   assign irq = stat_reg[STAT_INT_BIT];
endmodule

// File: rtl/xlc_checker.sv
module xlc_checker #(
   parameter int BYTE_W = 8,
   localparam int CNT_W = 2 * BYTE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid,
   input logic [1:0]        wr_addr,
   input logic [BYTE_W-1:0] wr_data,
   input logic              xfer_go,
   input logic              irq_ack,
   input logic              mem_valid,
   input logic              mem_to_dev,
   input logic              busy,
   input logic [CNT_W-1:0]  xfer_cnt,
   input logic [7:0]        stat_reg,
   input logic [7:0]        intr_reg,
   input logic              irq,
   input logic              fin_w
);
   logic [BYTE_W-1:0] sh_lo, sh_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_lo <= '0;
         sh_hi <= '0;
      end else if (wr_valid && wr_addr == 2'd0) sh_lo <= wr_data;
      else if (wr_valid && wr_addr == 2'd1) sh_hi <= wr_data;
   end

   a_r1_reload_count: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_addr == 2'd2 && wr_data[BYTE_W-1] && !fin_w)
      |=> xfer_cnt == {sh_hi, sh_lo});

   a_r2_plain_cmd_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_addr == 2'd2 && !wr_data[BYTE_W-1] && !fin_w)
      |=> $stable(xfer_cnt));

   a_r5_dir_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(mem_to_dev));

   a_r6_start_clears_tc: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_go && !busy && !fin_w) |=> !stat_reg[4]);

   a_r8_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_valid);

   a_r9_completion_regs: assert property (@(posedge clk) disable iff (!rst_n)
      fin_w |=> (irq && stat_reg[4] && intr_reg == 8'h10 && xfer_cnt == '0));

   a_r11_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_ack) |=> irq);

   a_r11_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !fin_w) |=> !irq);
endmodule

bind xfer_len_ctrl xlc_checker #(.BYTE_W(BYTE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
   .wr_data(wr_data), .xfer_go(xfer_go), .irq_ack(irq_ack),
   .mem_valid(mem_valid), .mem_to_dev(mem_to_dev), .busy(busy),
   .xfer_cnt(xfer_cnt), .stat_reg(stat_reg), .intr_reg(intr_reg),
   .irq(irq), .fin_w(fin_w)
);

// File: tb/xfer_len_ctrl_tb_top.sv
module xfer_len_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_valid = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        xfer_go = 1'b0, cmd_phase = 1'b0, dev_avail = 1'b1;
   logic        dev_done = 1'b0, mem_ready = 1'b1, irq_ack = 1'b0;
   logic [23:0] dev_remain = '0;
   logic        mem_valid, mem_to_dev, busy, irq;
   logic [15:0] xfer_cnt;
   logic [7:0]  stat_reg, intr_reg;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   xfer_len_ctrl dut_i (
      .clk, .rst_n, .wr_valid, .wr_addr, .wr_data, .xfer_go, .cmd_phase,
      .dev_remain, .dev_avail, .dev_done, .mem_ready, .irq_ack,
      .mem_valid, .mem_to_dev, .busy, .xfer_cnt, .stat_reg, .intr_reg, .irq
   );

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [7:0] d);
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic do_xfer(int cnt, bit cmd, int rem, bit stall);
      int  full, mag, len, beats, idle, dir_err, gate_err, cmd_err, c_last, c_irq;
      bit  hold, dir;
      full = (cnt == 0) ? 65536 : cnt;
      mag  = (rem < 0) ? -rem : rem;
      if (cmd) len = (full < 32) ? full : 32;
      else     len = (full < mag) ? full : mag;
      hold = !cmd && (mag < full);
      dir  = cmd || (rem < 0);
      wr(2'd0, 8'(cnt)); wr(2'd1, 8'(cnt >> 8)); wr(2'd2, 8'h90);
      #1 chk("R1 reload", int'(xfer_cnt), cnt);
      @(negedge clk);
      cmd_phase = cmd; dev_remain = rem[23:0]; xfer_go = 1'b1;
      dev_avail = 1'b1; mem_ready = 1'b1;
      @(negedge clk);
      xfer_go = 1'b0;
      #1;
      chk("R6 tc cleared", int'(stat_reg[4]), 0);
      chk("R6 busy", int'(busy), 1);
      beats = 0; idle = 0; dir_err = 0; gate_err = 0; cmd_err = 0;
      c_last = -1; c_irq = -1;
      for (int c = 0; c < 140000; c++) begin
         if (c > 0) begin
            @(negedge clk);
            if (stall) begin
               mem_ready = (c % 3) != 1;
               dev_avail = (c % 4) != 2;
            end
            if (hold && beats == len && idle == 2) begin
               xfer_go = 1'b1; cmd_phase = 1'b1;
            end else xfer_go = 1'b0;
            #1;
         end
         if (!cmd && !dev_avail && mem_valid) gate_err++;
         if (cmd && beats < len && !mem_valid) cmd_err++;
         if (mem_valid && mem_ready) begin
            beats++; c_last = c;
            if (mem_to_dev !== dir) dir_err++;
         end
         if (irq) begin c_irq = c; break; end
         if (hold && beats == len) begin
            idle++;
            if (idle == 6) break;
         end
      end
      xfer_go = 1'b0;
      chk("R7 R12 beat count", beats, len);
      chk(cmd ? "R4 direction" : "R5 direction", dir_err, 0);
      chk("R8 data gated by ready", gate_err, 0);
      chk("R8 command ignores ready", cmd_err, 0);
      if (hold) begin
         chk("R10 held without done", int'(irq), 0);
         @(negedge clk); dev_done = 1'b1; cmd_phase = 1'b0;
         @(negedge clk); dev_done = 1'b0;
         #1 chk("R10 release after done", int'(irq), 1);
      end else begin
         chk("R9 irq raised", int'(irq), 1);
         if (len > 0) chk("R9 latency", c_irq - c_last, 1);
      end
      chk("R9 status", int'(stat_reg), 8'h90);
      chk("R9 intr", int'(intr_reg), 8'h10);
      chk("R9 count cleared", int'(xfer_cnt), 0);
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
      #1;
      chk("R11 ack clears irq", int'(irq), 0);
      chk("R11 status after ack", int'(stat_reg), 8'h10);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int cnts[8];
      int rems[13];
      cnts = '{1, 2, 5, 31, 32, 33, 40, 300};
      rems = '{-400, -40, -33, -32, -5, -1, 0, 1, 5, 32, 33, 40, 400};
      repeat (3) @(negedge clk);
      #1;
      chk("R9 reset count", int'(xfer_cnt), 0);
      chk("R9 reset status", int'(stat_reg), 0);
      chk("R9 reset intr", int'(intr_reg), 0);
      chk("R11 reset irq", int'(irq), 0);
      chk("R6 reset busy", int'(busy), 0);
      @(negedge clk); rst_n = 1'b1;

      wr(2'd0, 8'h34); wr(2'd1, 8'h12);
      #1 chk("R2 byte writes alone", int'(xfer_cnt), 0);
      wr(2'd2, 8'h05);
      #1 chk("R2 command without flag", int'(xfer_cnt), 0);
      wr(2'd2, 8'h81);
      #1 chk("R1 command with flag", int'(xfer_cnt), 16'h1234);
      wr(2'd0, 8'h00);
      #1 chk("R2 later byte write", int'(xfer_cnt), 16'h1234);

      for (int s = 0; s < 2; s++)
         for (int i = 0; i < 8; i++)
            for (int j = 0; j < 13; j++)
               for (int m = 0; m < 2; m++)
                  if (m == 1 || j < 2 || (i % 3) == 0)
                     do_xfer(cnts[i], m[0], rems[j], s[0]);

      do_xfer(0, 1'b1, 0, 1'b0);      // R3 zero count against command cap
      do_xfer(0, 1'b0, -100, 1'b1);   // R3 zero count, device short: hold
      do_xfer(0, 1'b0, 70000, 1'b0);  // R3 zero count moves 65536 bytes

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule